// File: doc/BRIEF.md
# Overlapping Subregion Response Router

This block sits between a wavelet stage and a bank of per-window accumulators in a feature descriptor pipeline. It receives a serial, raster-ordered patch of 24×24 horizontal and vertical wavelet responses centred on one feature point. It works out where each response lies in the patch and copies it to every one of sixteen 9×9 windows that cover that spot. Sixteen weighting and summing units downstream can then run side by side.

The windows start every 5 responses along each axis, so neighbouring windows share a four-wide band. A response in such a band leaves on two output ports. A response in a shared corner leaves on four. Each output port also carries the response's row and column inside its own window, ready to address a weighting mask. A start pulse marks the first response of a patch. Once a full patch has arrived, further responses are dropped until the next start.

Top module: `srr_router`

## Requirements
- R1: After reset, every valid output of both port sets is low, and responses are dropped until a start pulse arrives.
- R2: An accepted response appears on its ports exactly one clock cycle later, carrying unchanged dx data on the dx set and dy data on the dy set.
- R3: Window index p = 4·wr + wc (wr, wc in 0..3) covers patch rows 5·wr..5·wr+8 and columns 5·wc..5·wc+8. A response at (row, col) raises valid on exactly the ports whose window contains it, which is 1, 2 or 4 ports. Examples: (0,0) raises 1 port, (0,5) raises 2 ports and (5,5) raises 4 ports.
- R4: Along with valid, each port outputs local row = row − 5·wr and local column = col − 5·wc. Both are in 0..8, both are 4 bits wide, and both have the same latency as valid.
- R5: Accepted responses are taken in raster order. The column counts 0..23, and after column 23 it returns to 0 on the next row.
- R6: A start pulse clears the position to (0,0). If valid is high in the same cycle as start, that response is placed at (0,0).
- R7: After the 576th response of a patch, further responses raise no valid until the next start pulse.
- R8: A start pulse with valid low accepts nothing, and the next valid response is placed at (0,0).
- R9: A cycle with valid low raises no output valid in the following cycle and does not move the position.
- R10: The dx and dy port sets always show the same valid pattern and the same local coordinates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A response pair is present this cycle |
| in_start | input | 1 | First cycle of a new patch; clears the position |
| in_dx | input | DW | Horizontal response |
| in_dy | input | DW | Vertical response |
| dx_vld | output | 16 | Per-window valid, dx set; bit p is window p |
| dx_data | output | 16·DW | Per-window dx sample, window p at bits p·DW upward |
| dx_lrow | output | 64 | Per-window local row, 4 bits per window |
| dx_lcol | output | 64 | Per-window local column, 4 bits per window |
| dy_vld | output | 16 | Per-window valid, dy set |
| dy_data | output | 16·DW | Per-window dy sample |
| dy_lrow | output | 64 | Per-window local row, dy set |
| dy_lcol | output | 64 | Per-window local column, dy set |

## Verification
The assertions assume that the sender puts patches out in raster order and never marks more than one start per patch. They also assume the start and valid inputs are clean, known levels during every clock edge after reset. The bench drives every input on the falling edge and starts each patch with a start pulse. It also deliberately sends responses outside that contract: before any start, beyond the 576th response, and with idle gaps. It checks that the router drops these responses or pauses for them as R7, R8 and R9 require.

// File: rtl/srr_pkg.sv
package srr_pkg;
    localparam int PATCH = 24;
    localparam int WIN   = 9;
    localparam int STEP  = 5;
    localparam int NAX   = (PATCH - WIN) / STEP + 1;
    localparam int NSUB  = NAX * NAX;
    localparam int CW    = $clog2(PATCH);
    localparam int LW    = $clog2(WIN);

    typedef struct packed {
        logic          active;
        logic [CW-1:0] row;
        logic [CW-1:0] col;
    } cnt_t;
endpackage

// File: rtl/srr_pos_counter.sv
module srr_pos_counter
    import srr_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_start,
    output logic          take,
    output logic [CW-1:0] pos_row,
    output logic [CW-1:0] pos_col
);
    localparam logic [CW-1:0] LAST = CW'(PATCH - 1);

    cnt_t cnt_d, cnt_q;
    logic [CW-1:0] cur_row, cur_col;

    always_comb begin
        cur_row = in_start ? '0 : cnt_q.row;
        cur_col = in_start ? '0 : cnt_q.col;
        take    = in_valid && (in_start || cnt_q.active);
        cnt_d   = cnt_q;
        if (in_start) begin
            cnt_d.active = 1'b1;
            cnt_d.row    = '0;
            cnt_d.col    = '0;
        end
        if (take) begin
            if (cur_col == LAST) begin
                cnt_d.col = '0;
                if (cur_row == LAST) begin
                    cnt_d.active = 1'b0;
                    cnt_d.row    = '0;
                end else begin
                    cnt_d.row = cur_row + 1'b1;
                end
            end else begin
                cnt_d.col = cur_col + 1'b1;
                cnt_d.row = cur_row;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign pos_row = cur_row;
    assign pos_col = cur_col;

    // R5
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q.row <= LAST) && (cnt_q.col <= LAST));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_q.active && !in_start) |=> ($stable(cnt_q.row) && $stable(cnt_q.col)));

    // R9
    gap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !in_start) |=> ($stable(cnt_q.row) && $stable(cnt_q.col)));
endmodule

// File: rtl/srr_axis_decode.sv
module srr_axis_decode
    import srr_pkg::*;
(
    input  logic [CW-1:0]      coord,
    output logic [NAX-1:0]     member,
    output logic [NAX*LW-1:0]  local_pos
);
    for (genvar k = 0; k < NAX; k++) begin : g_win
        localparam logic [CW-1:0] LO = CW'(k * STEP);
        localparam logic [CW-1:0] HI = CW'(k * STEP + WIN - 1);
        always_comb begin
            member[k]             = (coord >= LO) && (coord <= HI);
            local_pos[k*LW +: LW] = LW'(coord - LO);
        end
    end
endmodule

// File: rtl/srr_port_reg.sv
module srr_port_reg
    import srr_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hit,
    input  logic [DW-1:0] sample,
    input  logic [LW-1:0] lrow,
    input  logic [LW-1:0] lcol,
    output logic          vld,
    output logic [DW-1:0] data,
    output logic [LW-1:0] row,
    output logic [LW-1:0] col
);
    typedef struct packed {
        logic          vld;
        logic [DW-1:0] data;
        logic [LW-1:0] row;
        logic [LW-1:0] col;
    } port_t;

    port_t port_d, port_q;

    always_comb begin
        port_d     = port_q;
        port_d.vld = hit;
        if (hit) begin
            port_d.data = sample;
            port_d.row  = lrow;
            port_d.col  = lcol;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) port_q <= '0;
        else        port_q <= port_d;
    end

    assign vld  = port_q.vld;
    assign data = port_q.data;
    assign row  = port_q.row;
    assign col  = port_q.col;

    // R4
    port_local_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vld |-> ((row <= LW'(WIN - 1)) && (col <= LW'(WIN - 1))));

    // R2
    port_data_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (vld && data == $past(sample)));
endmodule

// File: rtl/srr_router.sv
module srr_router
    import srr_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               in_start,
    input  logic [DW-1:0]      in_dx,
    input  logic [DW-1:0]      in_dy,
    output logic [NSUB-1:0]    dx_vld,
    output logic [NSUB*DW-1:0] dx_data,
    output logic [NSUB*LW-1:0] dx_lrow,
    output logic [NSUB*LW-1:0] dx_lcol,
    output logic [NSUB-1:0]    dy_vld,
    output logic [NSUB*DW-1:0] dy_data,
    output logic [NSUB*LW-1:0] dy_lrow,
    output logic [NSUB*LW-1:0] dy_lcol
);
    logic              take;
    logic [CW-1:0]     pos_row, pos_col;
    logic [NAX-1:0]    row_member, col_member;
    logic [NAX*LW-1:0] row_local, col_local;

    srr_pos_counter u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_start (in_start),
        .take     (take),
        .pos_row  (pos_row),
        .pos_col  (pos_col)
    );

    srr_axis_decode u_row_dec (
        .coord     (pos_row),
        .member    (row_member),
        .local_pos (row_local)
    );

    srr_axis_decode u_col_dec (
        .coord     (pos_col),
        .member    (col_member),
        .local_pos (col_local)
    );

    for (genvar wr = 0; wr < NAX; wr++) begin : g_wrow
        for (genvar wc = 0; wc < NAX; wc++) begin : g_wcol
            localparam int P = wr * NAX + wc;
            logic hit;
            assign hit = take && row_member[wr] && col_member[wc];

            srr_port_reg #(.DW(DW)) u_dx_port (
                .clk    (clk),
                .rst_n  (rst_n),
                .hit    (hit),
                .sample (in_dx),
                .lrow   (row_local[wr*LW +: LW]),
                .lcol   (col_local[wc*LW +: LW]),
                .vld    (dx_vld[P]),
                .data   (dx_data[P*DW +: DW]),
                .row    (dx_lrow[P*LW +: LW]),
                .col    (dx_lcol[P*LW +: LW])
            );

            srr_port_reg #(.DW(DW)) u_dy_port (
                .clk    (clk),
                .rst_n  (rst_n),
                .hit    (hit),
                .sample (in_dy),
                .lrow   (row_local[wr*LW +: LW]),
                .lcol   (col_local[wc*LW +: LW]),
                .vld    (dy_vld[P]),
                .data   (dy_data[P*DW +: DW]),
                .row    (dy_lrow[P*LW +: LW]),
                .col    (dy_lcol[P*LW +: LW])
            );
        end
    end

    // R3
    fanout_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|dx_vld) |-> ($countones(dx_vld) == 1 || $countones(dx_vld) == 2 ||
                       $countones(dx_vld) == 4));

    // R2
    accept_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (|dx_vld));

    // R9
    gap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (dx_vld == '0 && dy_vld == '0));

    // R10
    dir_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dx_vld == dy_vld) && (dx_lrow == dy_lrow) && (dx_lcol == dy_lcol));

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (dx_vld == '0 && dy_vld == '0));
endmodule

// File: tb/srr_router_bench.sv
module srr_router_bench;
    localparam int DW = 16;
    localparam int NS = 16;
    localparam int LW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_start = 1'b0;
    logic [DW-1:0] in_dx = '0;
    logic [DW-1:0] in_dy = '0;
    logic [NS-1:0]    dx_vld, dy_vld;
    logic [NS*DW-1:0] dx_data, dy_data;
    logic [NS*LW-1:0] dx_lrow, dx_lcol, dy_lrow, dy_lcol;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    srr_router #(.DW(DW)) u_srr_router (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start),
        .in_dx(in_dx), .in_dy(in_dy),
        .dx_vld(dx_vld), .dx_data(dx_data), .dx_lrow(dx_lrow), .dx_lcol(dx_lcol),
        .dy_vld(dy_vld), .dy_data(dy_data), .dy_lrow(dy_lrow), .dy_lcol(dy_lcol)
    );

    function automatic bit in_win(int r, int c, int p);
        int wr = p / 4;
        int wc = p % 4;
        return (r >= 5*wr) && (r <= 5*wr + 8) && (c >= 5*wc) && (c <= 5*wc + 8);
    endfunction

    // Compare all ports of both sets against the expected routing of one sample.
    task automatic check_ports(input bit on, input int r, input int c,
                               input logic [DW-1:0] edx, input logic [DW-1:0] edy,
                               input string tag);
        bit bad = 1'b0;
        checks++;
        for (int p = 0; p < NS; p++) begin
            bit ev = on && in_win(r, c, p);
            logic [LW-1:0] er = LW'(r - 5*(p/4));
            logic [LW-1:0] ec = LW'(c - 5*(p%4));
            bit mism = (dx_vld[p] !== ev) || (dy_vld[p] !== ev);
            if (ev)
                mism = mism || (dx_data[p*DW +: DW] !== edx) || (dy_data[p*DW +: DW] !== edy) ||
                       (dx_lrow[p*LW +: LW] !== er) || (dx_lcol[p*LW +: LW] !== ec) ||
                       (dy_lrow[p*LW +: LW] !== er) || (dy_lcol[p*LW +: LW] !== ec);
            if (mism && !bad) begin
                bad = 1'b1;
                errors++;
                $display("FAIL %s pos(%0d,%0d) port %0d: got vld=%b/%b dx=%h dy=%h row=%0d col=%0d expected vld=%b dx=%h dy=%h row=%0d col=%0d",
                         tag, r, c, p, dx_vld[p], dy_vld[p], dx_data[p*DW +: DW],
                         dy_data[p*DW +: DW], dx_lrow[p*LW +: LW], dx_lcol[p*LW +: LW],
                         ev, edx, edy, er, ec);
            end
        end
    endtask

    task automatic check_count(input int got, input int exp, input string tag);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s port count got %0d expected %0d", tag, got, exp);
        end
    endtask

    // Called at a falling edge: drive, wait one cycle, leave outputs to be checked.
    task automatic drive(input bit v, input bit s, input logic [DW-1:0] dx, input logic [DW-1:0] dy);
        in_valid = v;
        in_start = s;
        in_dx    = dx;
        in_dy    = dy;
        @(negedge clk);
        in_valid = 1'b0;
        in_start = 1'b0;
    endtask

    function automatic logic [DW-1:0] vdx(int i); return DW'(i * 3 + 7); endfunction
    function automatic logic [DW-1:0] vdy(int i); return DW'(16'hA000 ^ i); endfunction

    task automatic t_reset();
        check_ports(1'b0, 0, 0, '0, '0, "R1 reset");
    endtask

    task automatic t_prestart();
        drive(1'b1, 1'b0, 16'h1234, 16'h4321);
        check_ports(1'b0, 0, 0, '0, '0, "R1 R8 before start");
    endtask

    task automatic t_full_patch();
        for (int i = 0; i < 576; i++) begin
            int r = i / 24;
            int c = i % 24;
            drive(1'b1, i == 0, vdx(i), vdy(i));
            check_ports(1'b1, r, c, vdx(i), vdy(i), "R2 R3 R4 R5 R10");
            if (r == 0 && c == 0)  check_count($countones(dx_vld), 1, "R3 corner");
            if (r == 0 && c == 5)  check_count($countones(dx_vld), 2, "R3 edge band");
            if (r == 5 && c == 5)  check_count($countones(dx_vld), 4, "R3 overlap corner");
            if (r == 23 && c == 23) check_count($countones(dx_vld), 1, "R3 last");
        end
    endtask

    task automatic t_overrun();
        for (int i = 0; i < 3; i++) begin
            drive(1'b1, 1'b0, vdx(900 + i), vdy(900 + i));
            check_ports(1'b0, 0, 0, '0, '0, "R7 beyond patch");
        end
        drive(1'b1, 1'b1, vdx(1), vdy(1));
        check_ports(1'b1, 0, 0, vdx(1), vdy(1), "R6 R7 restart");
    endtask

    task automatic t_gaps();
        drive(1'b1, 1'b1, vdx(10), vdy(10));
        check_ports(1'b1, 0, 0, vdx(10), vdy(10), "R6 gap start");
        drive(1'b1, 1'b0, vdx(11), vdy(11));
        check_ports(1'b1, 0, 1, vdx(11), vdy(11), "R5 gap");
        for (int i = 0; i < 2; i++) begin
            drive(1'b0, 1'b0, vdx(99), vdy(99));
            check_ports(1'b0, 0, 0, '0, '0, "R9 idle");
        end
        drive(1'b1, 1'b0, vdx(12), vdy(12));
        check_ports(1'b1, 0, 2, vdx(12), vdy(12), "R9 resume");
    endtask

    task automatic t_restart_mid();
        for (int i = 3; i < 30; i++) drive(1'b1, 1'b0, vdx(i), vdy(i));
        check_ports(1'b1, 1, 5, vdx(29), vdy(29), "R5 row wrap");
        drive(1'b1, 1'b1, vdx(40), vdy(40));
        check_ports(1'b1, 0, 0, vdx(40), vdy(40), "R6 start with valid");
        drive(1'b1, 1'b0, vdx(41), vdy(41));
        check_ports(1'b1, 0, 1, vdx(41), vdy(41), "R6 after start");
        drive(1'b0, 1'b1, vdx(42), vdy(42));
        check_ports(1'b0, 0, 0, '0, '0, "R8 bare start");
        drive(1'b1, 1'b0, vdx(43), vdy(43));
        check_ports(1'b1, 0, 0, vdx(43), vdy(43), "R8 first after bare start");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_prestart();
        t_full_patch();
        t_overrun();
        t_gaps();
        t_restart_mid();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule